// File: doc/BRIEF.md
# Octal Bidirectional Latched Inverting Transceiver

This block sits between two eight-bit buses, an A side and a B side, and moves data in either direction through its own bank of storage, one bank per direction. Each direction has three active-low controls: an enable that gates both storage loading and output driving, a latch control that opens the storage, and an output control that lets the opposite port drive. The value a port drives is always the bitwise complement of what its bank holds or passes through.

On chip there are no tri-state nets. Each port is therefore split into an input bus, an output bus and a single drive flag, and a pad ring or an on-chip bus mux combines them. Storage is written on the block clock. When a bank is open, its output follows the input with no clock in between. When the bank closes, it keeps the value it sampled at the last clock edge while it was open. An asynchronous active-low reset clears both banks to zero.

Top module: `octal_latch_xcvr`

## Requirements
- R1: After reset both banks hold all zeros. With a direction enabled, its latch control high and its output control low, the driving port shows all ones.
- R2: While eabN and leabN are both low, the A-to-B bank is open, and when bOe is high, bOut equals the complement of aIn in the same cycle with no clock edge needed.
- R3: When leabN goes high with eabN low, the bank keeps the aIn value sampled at the last clock edge while it was open. Later changes of aIn do not reach bOut.
- R4: When eabN goes high while leabN is low, the bank closes in the same way. After eabN returns low with leabN high, bOut shows the complement of the value held before eabN rose.
- R5: While eabN is high, the A-to-B bank ignores leabN and aIn. Its contents are unchanged when the bank is next displayed.
- R6: bOe is 1 exactly when eabN and oeabN are both low. oeabN has no effect on what the bank stores.
- R7: Every driven bit is the inverse of the stored or passed-through bit: a 1 in the bank appears as a 0 on the port.
- R8: The B-to-A direction obeys R2 to R7 with ebaN, lebaN, oebaN, bIn, aOut and aOe in place of the A-to-B signals.
- R9: When both directions drive at the same time, each output is still produced correctly from its own bank and its own controls.
- R10: Whenever a port's drive flag is 0, its output bus is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock on which the banks are written |
| rstN | input | 1 | Asynchronous active-low reset, clears both banks |
| eabN | input | 1 | A-to-B enable, active low |
| leabN | input | 1 | A-to-B latch control, active low (low = open) |
| oeabN | input | 1 | A-to-B output control, active low |
| ebaN | input | 1 | B-to-A enable, active low |
| lebaN | input | 1 | B-to-A latch control, active low (low = open) |
| oebaN | input | 1 | B-to-A output control, active low |
| aIn | input | WIDTH | Data seen on the A pins |
| aOut | output | WIDTH | Data driven onto the A pins (inverted B-to-A bank) |
| aOe | output | 1 | High when the A pins are driven |
| bIn | input | WIDTH | Data seen on the B pins |
| bOut | output | WIDTH | Data driven onto the B pins (inverted A-to-B bank) |
| bOe | output | 1 | High when the B pins are driven |

## Verification
The bench builds the block with WIDTH set to 4. This makes it practical to sweep all 64 combinations of the six control inputs against all 16 data values on each side, so every mix of open, closed, driven and idle states occurs for both directions. A reference model in the bench updates its own copy of each bank at every clock edge. A pseudo-random control and data sequence then covers transitions between those states. Directed sequences pin down closing by the latch control, closing by the enable, holding while disabled, and simultaneous driving in both directions.

// File: rtl/octal_xcvr_pkg.sv
package octal_xcvr_pkg;

  // Strobes from the control decode to the datapath, one pair per direction
  typedef struct packed {
    logic abLoad;   // A-to-B bank open (follows aIn, written each clock)
    logic abDrive;  // B port driven
    logic baLoad;   // B-to-A bank open
    logic baDrive;  // A port driven
  } xcvrStrobes_t;

endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import octal_xcvr_pkg::*;
(
  input  logic         eabN,
  input  logic         leabN,
  input  logic         oeabN,
  input  logic         ebaN,
  input  logic         lebaN,
  input  logic         oebaN,
  output xcvrStrobes_t strobes
);

  // The direction enable gates both loading and driving
  always_comb begin
    strobes.abLoad  = ~eabN & ~leabN;
    strobes.abDrive = ~eabN & ~oeabN;
    strobes.baLoad  = ~ebaN & ~lebaN;
    strobes.baDrive = ~ebaN & ~oebaN;
  end

endmodule

// File: rtl/xcvr_latch_bank.sv
module xcvr_latch_bank #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic             drive,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] dOut,
  output logic [WIDTH-1:0] store
);

  logic [WIDTH-1:0] passQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     store <= '0;
    else if (load) store <= dIn;
  end

  // Open bank passes input straight through; closed bank shows its store
  always_comb begin
    passQ = load ? dIn : store;
    dOut  = drive ? ~passQ : '0;
  end

endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import octal_xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  xcvrStrobes_t     strobes,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] bOut,
  output logic [WIDTH-1:0] abStore,
  output logic [WIDTH-1:0] baStore
);

  xcvr_latch_bank #(.WIDTH(WIDTH)) u_abBank (
    .clk  (clk),
    .rstN (rstN),
    .load (strobes.abLoad),
    .drive(strobes.abDrive),
    .dIn  (aIn),
    .dOut (bOut),
    .store(abStore)
  );

  xcvr_latch_bank #(.WIDTH(WIDTH)) u_baBank (
    .clk  (clk),
    .rstN (rstN),
    .load (strobes.baLoad),
    .drive(strobes.baDrive),
    .dIn  (bIn),
    .dOut (aOut),
    .store(baStore)
  );

endmodule

// File: rtl/octal_latch_xcvr.sv
module octal_latch_xcvr
  import octal_xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             eabN,
  input  logic             leabN,
  input  logic             oeabN,
  input  logic             ebaN,
  input  logic             lebaN,
  input  logic             oebaN,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOe,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] bOut,
  output logic             bOe
);

  xcvrStrobes_t     strobes;
  logic [WIDTH-1:0] abStore;
  logic [WIDTH-1:0] baStore;

  xcvr_ctrl u_ctrl (
    .eabN   (eabN),
    .leabN  (leabN),
    .oeabN  (oeabN),
    .ebaN   (ebaN),
    .lebaN  (lebaN),
    .oebaN  (oebaN),
    .strobes(strobes)
  );

  xcvr_datapath #(.WIDTH(WIDTH)) u_path (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .aIn    (aIn),
    .bIn    (bIn),
    .aOut   (aOut),
    .bOut   (bOut),
    .abStore(abStore),
    .baStore(baStore)
  );

  assign bOe = strobes.abDrive;
  assign aOe = strobes.baDrive;

endmodule

// File: rtl/octal_xcvr_chk.sv
module octal_xcvr_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             eabN,
  input logic             leabN,
  input logic             oeabN,
  input logic             ebaN,
  input logic             lebaN,
  input logic             oebaN,
  input logic [WIDTH-1:0] aIn,
  input logic [WIDTH-1:0] bIn,
  input logic [WIDTH-1:0] aOut,
  input logic [WIDTH-1:0] bOut,
  input logic             aOe,
  input logic             bOe,
  input logic [WIDTH-1:0] abStore,
  input logic [WIDTH-1:0] baStore
);

  // R2
  ab_transp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!eabN && !leabN && !oeabN) |-> (bOut == ~aIn));

  // R3
  ab_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(!eabN && !leabN)) |-> (abStore == $past(aIn)));

  // R5
  ab_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(eabN) |-> $stable(abStore));

  // R6
  ab_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eabN || oeabN) |-> !bOe);

  // R10
  b_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bOe |-> (bOut == '0));

  // R8
  ba_transp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ebaN && !lebaN && !oebaN) |-> (aOut == ~bIn));

  // R8
  ba_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(ebaN) |-> $stable(baStore));

  // R10
  a_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !aOe |-> (aOut == '0));

  // R9
  both_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aOe && bOe) |-> ((bOut == ~(leabN ? abStore : aIn)) &&
                      (aOut == ~(lebaN ? baStore : bIn))));

endmodule

bind octal_latch_xcvr octal_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .eabN   (eabN),
  .leabN  (leabN),
  .oeabN  (oeabN),
  .ebaN   (ebaN),
  .lebaN  (lebaN),
  .oebaN  (oebaN),
  .aIn    (aIn),
  .bIn    (bIn),
  .aOut   (aOut),
  .bOut   (bOut),
  .aOe    (aOe),
  .bOe    (bOe),
  .abStore(abStore),
  .baStore(baStore)
);

// File: tb/octal_latch_xcvr_tb.sv
`timescale 1ns/1ps
module octal_latch_xcvr_tb;

  localparam int W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic eabN = 1'b1, leabN = 1'b1, oeabN = 1'b1;
  logic ebaN = 1'b1, lebaN = 1'b1, oebaN = 1'b1;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic [W-1:0] aOut, bOut;
  logic aOe, bOe;

  int nTests = 0;
  int nFail = 0;
  bit done = 1'b0;

  logic [W-1:0] abM = '0;
  logic [W-1:0] baM = '0;

  always #10 clk = ~clk;

  octal_latch_xcvr #(.WIDTH(W)) u_dut (
    .clk(clk), .rstN(rstN),
    .eabN(eabN), .leabN(leabN), .oeabN(oeabN),
    .ebaN(ebaN), .lebaN(lebaN), .oebaN(oebaN),
    .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // c = {eabN, leabN, oeabN, ebaN, lebaN, oebaN}
  task automatic cyc(input logic [5:0] c, input logic [W-1:0] a, input logic [W-1:0] b,
                     input string tag = "", input logic [W-1:0] xb = '0,
                     input logic [W-1:0] xa = '0, input bit useB = 0, input bit useA = 0);
    logic abOpen, abDrv, baOpen, baDrv;
    logic [W-1:0] expB, expA;
    @(negedge clk);
    {eabN, leabN, oeabN, ebaN, lebaN, oebaN} = c;
    aIn = a;
    bIn = b;
    #1;
    abOpen = !c[5] && !c[4];
    abDrv  = !c[5] && !c[3];
    baOpen = !c[2] && !c[1];
    baDrv  = !c[2] && !c[0];
    expB = abDrv ? ~(abOpen ? a : abM) : '0;
    expA = baDrv ? ~(baOpen ? b : baM) : '0;
    chk("R6 bOe", {{(W-1){1'b0}}, bOe}, {{(W-1){1'b0}}, abDrv});
    chk("R8 aOe", {{(W-1){1'b0}}, aOe}, {{(W-1){1'b0}}, baDrv});
    chk(!abDrv ? "R10 bOut" : (abOpen ? "R2 bOut" : "R3 bOut"), bOut, expB);
    chk(!baDrv ? "R10 aOut" : "R8 aOut", aOut, expA);
    if (useB) chk(tag, bOut, xb);
    if (useA) chk(tag, aOut, xa);
    @(posedge clk);
    if (abOpen) abM = a;
    if (baOpen) baM = b;
  endtask

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: closed banks after reset, both driven: all ones
    cyc(6'b010_010, 4'hA, 4'h5, "R1 reset state", 4'hF, 4'hF, 1, 1);
    // R7: inversion on an open bank
    cyc(6'b000_111, 4'b0101, 4'h0, "R7 inversion", 4'b1010, '0, 1, 0);
    // R3: close by latch control
    cyc(6'b000_111, 4'd13, 4'h0);
    cyc(6'b010_111, 4'd2, 4'h0, "R3 capture by latch control", ~4'd13, '0, 1, 0);
    // R4: close by enable
    cyc(6'b000_111, 4'd9, 4'h0);
    cyc(6'b100_111, 4'd3, 4'h0);
    cyc(6'b010_111, 4'd6, 4'h0, "R4 capture by enable", ~4'd9, '0, 1, 0);
    // R5: hold while disabled, latch control toggling
    cyc(6'b000_111, 4'd12, 4'h0);
    cyc(6'b100_111, 4'd1, 4'h0);
    cyc(6'b110_111, 4'd2, 4'h0);
    cyc(6'b100_111, 4'd3, 4'h0);
    cyc(6'b010_111, 4'd7, 4'h0, "R5 hold while disabled", ~4'd12, '0, 1, 0);
    // R6: output control does not affect storage
    cyc(6'b001_111, 4'd5, 4'h0);
    cyc(6'b010_111, 4'd8, 4'h0, "R6 oeab ignored by storage", ~4'd5, '0, 1, 0);
    // R8: reverse direction capture
    cyc(6'b111_000, 4'h0, 4'd11);
    cyc(6'b111_010, 4'h0, 4'd4, "R8 reverse capture", '0, ~4'd11, 0, 1);
    // R9: both directions driving
    cyc(6'b000_000, 4'd5, 4'd10, "R9 both driving", 4'b1010, 4'b0101, 1, 1);
    // Exhaustive sweep of controls and data
    for (int c = 0; c < 64; c++)
      for (int d = 0; d < 16; d++)
        cyc(c[5:0], d[3:0], ~d[3:0] ^ c[3:0]);
    // Pseudo-random transitions
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[5:0], lfsr[9:6], lfsr[13:10]);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule